// File: doc/BRIEF.md
# Event Translation Command Executor

This block carries out one event-directed command at a time: raise, clear or discard. A command names a device and an event. The block walks three tables in a fixed order. It first reads the device's entry, then the event's translation entry, then the entry of the collection that the translation points at. These lookups yield a target processor number and a physical interrupt number. The block then issues one pending-state update to that processor. A raise sets the pending state, while clear and discard remove it. For a discard, the block also asks for the translation entry to be overwritten with zeros.

Each identifier is checked against its table size before the lookup that depends on it is issued. An out-of-range identifier or an entry marked not valid drops the command, and the verdict is continue. A faulting read, or a failed zero-write, ends the command with the verdict stall. A surrounding queue walker uses that verdict to decide whether it may move on to the next command.

Table storage sits outside the block, behind a request/response lookup port. The controller has seven named states:

- **IDLE** accepts a command.
- **DEV_RD**, **XLT_RD** and **COL_RD** each wait for one lookup.
- **NOTIFY** emits the pending update.
- **WIPE** waits for the zero-write.
- **FINISH** reports the verdict.

Transitions:

- **accept**: IDLE→DEV_RD.
- **reject_dev**: IDLE→FINISH.
- **dev_hit**: DEV_RD→XLT_RD.
- **xlt_hit**: XLT_RD→COL_RD.
- **col_hit**: COL_RD→NOTIFY.
- **drop** or **fault**: any read state→FINISH.
- **to_wipe**: NOTIFY→WIPE.
- **notify_done**: NOTIFY→FINISH.
- **wipe_done**: WIPE→FINISH.
- **retire**: FINISH→IDLE.

Top module: `etd_translator`

## Requirements
- R1: A command whose device ID is not below DEV_ENTRIES finishes with verdict continue (`done_stall`=0). It issues no lookup and no pending update.
- R2: If the device entry's valid bit (bit 0) is clear, the command finishes with continue after exactly one lookup (kind 0).
- R3: The device entry's size field sits in bits [5:1]. An event ID that is not below 2^(size+1) finishes the command with continue, and no translation lookup is issued.
- R4: If the translation entry's valid bit (bit 0) is clear, the command finishes with continue after two lookups.
- R5: The translation entry's collection ID sits in bits [COLL_W:1]. If it is not below COLL_ENTRIES, the command finishes with continue and no collection lookup is issued.
- R6: The collection entry's processor number sits in bits [PROC_W:1]. A collection entry with bit 0 clear, or with a processor number not below NUM_PROC, finishes the command with continue and no pending update.
- R7: A command that passes all checks emits exactly one one-cycle `pend_valid` pulse. The pulse carries the processor number, the interrupt ID from translation bits [8+INTID_W:9], and `pend_set`. `pend_set`=1 for op 0 (raise) and 0 for op 1 (clear), op 2 (discard) and op 3 (treated as clear).
- R8: After its pending update, a discard issues a lookup of kind 3 (zero-write) for the same device and event. A fault on that write gives stall; otherwise the verdict is continue. No other op issues kind 3.
- R9: A fault response on a device, translation or collection read finishes the command with stall in the following cycle, whatever the response data holds.
- R10: Lookups come strictly in the order kind 0 (device), 1 (translation), 2 (collection), 3 (zero-write). While waiting for `lk_ack`, `lk_req`, `lk_kind`, `lk_dev` and `lk_idx` stay stable. `lk_dev` carries the device ID. `lk_idx` is 0 for kind 0, the event ID for kinds 1 and 3, and the collection ID for kind 2.
- R11: `cmd_ready` is high only while idle, including right after reset. Each accepted command produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if offered |
| cmd_op | input | 2 | 0 raise, 1 clear, 2 discard, 3 clear |
| cmd_dev | input | DEV_W | Device ID |
| cmd_evt | input | EVT_W | Event ID |
| lk_req | output | 1 | Lookup request, held until acknowledged |
| lk_kind | output | 2 | 0 device, 1 translation, 2 collection, 3 zero-write |
| lk_dev | output | DEV_W | Device key of the lookup |
| lk_idx | output | IDX_W | Event or collection index of the lookup |
| lk_ack | input | 1 | Lookup response present |
| lk_fault | input | 1 | Lookup ended in a memory fault |
| lk_rdata | input | ENTRY_W | Entry word returned by the lookup |
| pend_valid | output | 1 | Pending-state update pulse |
| pend_set | output | 1 | 1 set pending, 0 clear pending |
| pend_proc | output | PROC_W | Target processor number |
| pend_intid | output | INTID_W | Physical interrupt ID |
| done | output | 1 | Command finished, one-cycle pulse |
| done_stall | output | 1 | Verdict with done: 1 stall, 0 continue |

## Verification
A single lookup response can carry both a fault and entry data that would, on its own, drop the command. Examples are a clear valid bit, an event outside the size, an out-of-range collection or an out-of-range processor. The fault and the drop check therefore fall in the same cycle. The bench provokes this by returning the normally computed entry word together with `lk_fault` at each of the four lookup kinds in turn, for every device, event and op. It judges the outcome by requiring stall and a request count that ends at the faulting lookup.

// File: rtl/etd_pkg.sv
`timescale 1ns/1ps
package etd_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_CLEAR = 2'd1,
        OP_DISC  = 2'd2,
        OP_RSVD  = 2'd3
    } etd_op_e;

    typedef enum logic [1:0] {
        LK_DEV  = 2'd0,
        LK_XLT  = 2'd1,
        LK_COL  = 2'd2,
        LK_WIPE = 2'd3
    } etd_lk_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_DEV_RD = 3'd1,
        S_XLT_RD = 3'd2,
        S_COL_RD = 3'd3,
        S_NOTIFY = 3'd4,
        S_WIPE   = 3'd5,
        S_FINISH = 3'd6
    } etd_state_e;

    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned FIELD_LO  = 1;
    localparam int unsigned SIZE_W    = 5;
    localparam int unsigned INTID_LO  = 9;

endpackage

// File: rtl/etd_entry_unpack.sv
`timescale 1ns/1ps
module etd_entry_unpack
    import etd_pkg::*;
#(
    parameter int unsigned ENTRY_W = 32,
    parameter int unsigned COLL_W  = 6,
    parameter int unsigned PROC_W  = 4,
    parameter int unsigned INTID_W = 16
) (
    input  logic [ENTRY_W-1:0] word,
    output logic               ent_valid,
    output logic [SIZE_W-1:0]  ent_size,
    output logic [COLL_W-1:0]  ent_coll,
    output logic [PROC_W-1:0]  ent_proc,
    output logic [INTID_W-1:0] ent_intid
);

    localparam int unsigned SIZE_HI  = FIELD_LO + SIZE_W - 1;
    localparam int unsigned COLL_HI  = FIELD_LO + COLL_W - 1;
    localparam int unsigned PROC_HI  = FIELD_LO + PROC_W - 1;
    localparam int unsigned INTID_HI = INTID_LO + INTID_W - 1;

    logic unused_word;

    // Entry word layouts shared by the three tables:
    // device:      [0] valid, [5:1] size
    // translation: [0] valid, [COLL_W:1] collection, [INTID_HI:9] interrupt
    // collection:  [0] valid, [PROC_W:1] processor
    assign ent_valid   = word[VALID_BIT];
    assign ent_size    = word[SIZE_HI:FIELD_LO];
    assign ent_coll    = word[COLL_HI:FIELD_LO];
    assign ent_proc    = word[PROC_HI:FIELD_LO];
    assign ent_intid   = word[INTID_HI:INTID_LO];
    assign unused_word = ^word;

endmodule

// File: rtl/etd_limit_chk.sv
`timescale 1ns/1ps
module etd_limit_chk
    import etd_pkg::*;
#(
    parameter int unsigned DEV_W        = 8,
    parameter int unsigned EVT_W        = 8,
    parameter int unsigned COLL_W       = 6,
    parameter int unsigned PROC_W       = 4,
    parameter int unsigned DEV_ENTRIES  = 200,
    parameter int unsigned COLL_ENTRIES = 48,
    parameter int unsigned NUM_PROC     = 12
) (
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [EVT_W-1:0]  evt_id,
    input  logic [SIZE_W-1:0] size,
    input  logic [COLL_W-1:0] coll,
    input  logic [PROC_W-1:0] proc,
    output logic              dev_ok,
    output logic              evt_ok,
    output logic              coll_ok,
    output logic              proc_ok
);

    localparam int unsigned SP_W = SIZE_W + 1;

    logic [SP_W-1:0]  size_p1;
    logic [EVT_W-1:0] over;

    assign size_p1 = SP_W'(size) + SP_W'(1);

    // An event is legal when no bit at or above size+1 is set.
    for (genvar gi = 0; gi < EVT_W; gi++) begin : g_evt_bit
        localparam logic [SP_W-1:0] POS = SP_W'(gi);
        assign over[gi] = evt_id[gi] && (POS >= size_p1);
    end

    assign evt_ok  = ~|over;
    assign dev_ok  = 32'(dev_id) < DEV_ENTRIES;
    assign coll_ok = 32'(coll) < COLL_ENTRIES;
    assign proc_ok = 32'(proc) < NUM_PROC;

endmodule

// File: rtl/etd_seq.sv
`timescale 1ns/1ps
module etd_seq
    import etd_pkg::*;
#(
    parameter int unsigned DEV_W   = 8,
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned COLL_W  = 6,
    parameter int unsigned PROC_W  = 4,
    parameter int unsigned INTID_W = 16,
    parameter int unsigned IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [DEV_W-1:0]   cmd_dev,
    input  logic [EVT_W-1:0]   cmd_evt,
    output logic               cmd_ready,
    output logic               lk_req,
    output logic [1:0]         lk_kind,
    output logic [DEV_W-1:0]   lk_dev,
    output logic [IDX_W-1:0]   lk_idx,
    input  logic               lk_ack,
    input  logic               lk_fault,
    input  logic               rsp_valid,
    input  logic [COLL_W-1:0]  rsp_coll,
    input  logic [PROC_W-1:0]  rsp_proc,
    input  logic [INTID_W-1:0] rsp_intid,
    input  logic               dev_ok,
    input  logic               evt_ok,
    input  logic               coll_ok,
    input  logic               proc_ok,
    output logic [EVT_W-1:0]   held_evt,
    output logic               pend_valid,
    output logic               pend_set,
    output logic [PROC_W-1:0]  pend_proc,
    output logic [INTID_W-1:0] pend_intid,
    output logic               done,
    output logic               done_stall
);

    etd_state_e         state_q, state_d;
    etd_op_e            op_q;
    logic [DEV_W-1:0]   dev_q;
    logic [EVT_W-1:0]   evt_q;
    logic [COLL_W-1:0]  coll_q;
    logic [PROC_W-1:0]  proc_q;
    logic [INTID_W-1:0] intid_q;
    logic               stall_q, stall_d;

    // Next-state logic: each read state leaves on lk_ack; a fault
    // outranks every content check made on the same response.
    always_comb begin
        state_d = state_q;
        stall_d = stall_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    stall_d = 1'b0;
                    state_d = dev_ok ? S_DEV_RD : S_FINISH;
                end
            end
            S_DEV_RD: begin
                if (lk_ack) begin
                    if (lk_fault) begin
                        stall_d = 1'b1;
                        state_d = S_FINISH;
                    end else if (!rsp_valid || !evt_ok) begin
                        state_d = S_FINISH;
                    end else begin
                        state_d = S_XLT_RD;
                    end
                end
            end
            S_XLT_RD: begin
                if (lk_ack) begin
                    if (lk_fault) begin
                        stall_d = 1'b1;
                        state_d = S_FINISH;
                    end else if (!rsp_valid || !coll_ok) begin
                        state_d = S_FINISH;
                    end else begin
                        state_d = S_COL_RD;
                    end
                end
            end
            S_COL_RD: begin
                if (lk_ack) begin
                    if (lk_fault) begin
                        stall_d = 1'b1;
                        state_d = S_FINISH;
                    end else if (!rsp_valid || !proc_ok) begin
                        state_d = S_FINISH;
                    end else begin
                        state_d = S_NOTIFY;
                    end
                end
            end
            S_NOTIFY: state_d = (op_q == OP_DISC) ? S_WIPE : S_FINISH;
            S_WIPE: begin
                if (lk_ack) begin
                    stall_d = lk_fault;
                    state_d = S_FINISH;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State and captured fields.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            stall_q <= 1'b0;
            op_q    <= OP_RAISE;
            dev_q   <= '0;
            evt_q   <= '0;
            coll_q  <= '0;
            proc_q  <= '0;
            intid_q <= '0;
        end else begin
            state_q <= state_d;
            stall_q <= stall_d;
            if (state_q == S_IDLE && cmd_valid) begin
                op_q  <= etd_op_e'(cmd_op);
                dev_q <= cmd_dev;
                evt_q <= cmd_evt;
            end
            if (state_q == S_XLT_RD && lk_ack) begin
                coll_q  <= rsp_coll;
                intid_q <= rsp_intid;
            end
            if (state_q == S_COL_RD && lk_ack) begin
                proc_q <= rsp_proc;
            end
        end
    end

    // Moore outputs.
    always_comb begin
        cmd_ready  = 1'b0;
        lk_req     = 1'b0;
        lk_kind    = LK_DEV;
        lk_idx     = '0;
        pend_valid = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_IDLE:   cmd_ready = 1'b1;
            S_DEV_RD: lk_req = 1'b1;
            S_XLT_RD: begin
                lk_req  = 1'b1;
                lk_kind = LK_XLT;
                lk_idx  = IDX_W'(evt_q);
            end
            S_COL_RD: begin
                lk_req  = 1'b1;
                lk_kind = LK_COL;
                lk_idx  = IDX_W'(coll_q);
            end
            S_NOTIFY: pend_valid = 1'b1;
            S_WIPE: begin
                lk_req  = 1'b1;
                lk_kind = LK_WIPE;
                lk_idx  = IDX_W'(evt_q);
            end
            S_FINISH: done = 1'b1;
            default:  cmd_ready = 1'b0;
        endcase
    end

    assign lk_dev     = dev_q;
    assign held_evt   = evt_q;
    assign pend_set   = (op_q == OP_RAISE);
    assign pend_proc  = proc_q;
    assign pend_intid = intid_q;
    assign done_stall = stall_q;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_ack |=> lk_req && $stable(lk_kind) && $stable(lk_dev) && $stable(lk_idx))
        else $error("lookup request changed before ack");

    p_fault_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_ack && lk_fault |=> done && done_stall)
        else $error("fault did not end in stall");

    p_pend_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> !pend_valid)
        else $error("pending pulse longer than one cycle");

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !lk_req && !pend_valid && !done)
        else $error("activity while idle");

    p_wipe_after_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_req && lk_kind == LK_WIPE) |-> $past(pend_valid) && !pend_set)
        else $error("zero-write without preceding clear");

endmodule

// File: rtl/etd_translator.sv
`timescale 1ns/1ps
module etd_translator
    import etd_pkg::*;
#(
    parameter int unsigned DEV_W        = 8,
    parameter int unsigned EVT_W        = 8,
    parameter int unsigned COLL_W       = 6,
    parameter int unsigned PROC_W       = 4,
    parameter int unsigned INTID_W      = 16,
    parameter int unsigned ENTRY_W      = 32,
    parameter int unsigned DEV_ENTRIES  = 200,
    parameter int unsigned COLL_ENTRIES = 48,
    parameter int unsigned NUM_PROC     = 12,
    localparam int unsigned IDX_W       = (EVT_W > COLL_W) ? EVT_W : COLL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [DEV_W-1:0]   cmd_dev,
    input  logic [EVT_W-1:0]   cmd_evt,
    output logic               lk_req,
    output logic [1:0]         lk_kind,
    output logic [DEV_W-1:0]   lk_dev,
    output logic [IDX_W-1:0]   lk_idx,
    input  logic               lk_ack,
    input  logic               lk_fault,
    input  logic [ENTRY_W-1:0] lk_rdata,
    output logic               pend_valid,
    output logic               pend_set,
    output logic [PROC_W-1:0]  pend_proc,
    output logic [INTID_W-1:0] pend_intid,
    output logic               done,
    output logic               done_stall
);

    logic               rsp_valid;
    logic [SIZE_W-1:0]  rsp_size;
    logic [COLL_W-1:0]  rsp_coll;
    logic [PROC_W-1:0]  rsp_proc;
    logic [INTID_W-1:0] rsp_intid;
    logic [EVT_W-1:0]   held_evt;
    logic               dev_ok, evt_ok, coll_ok, proc_ok;

    etd_entry_unpack #(
        .ENTRY_W(ENTRY_W), .COLL_W(COLL_W), .PROC_W(PROC_W), .INTID_W(INTID_W)
    ) u_unpack (
        .word(lk_rdata), .ent_valid(rsp_valid), .ent_size(rsp_size),
        .ent_coll(rsp_coll), .ent_proc(rsp_proc), .ent_intid(rsp_intid)
    );

    etd_limit_chk #(
        .DEV_W(DEV_W), .EVT_W(EVT_W), .COLL_W(COLL_W), .PROC_W(PROC_W),
        .DEV_ENTRIES(DEV_ENTRIES), .COLL_ENTRIES(COLL_ENTRIES), .NUM_PROC(NUM_PROC)
    ) u_limits (
        .dev_id(cmd_dev), .evt_id(held_evt), .size(rsp_size),
        .coll(rsp_coll), .proc(rsp_proc),
        .dev_ok(dev_ok), .evt_ok(evt_ok), .coll_ok(coll_ok), .proc_ok(proc_ok)
    );

    etd_seq #(
        .DEV_W(DEV_W), .EVT_W(EVT_W), .COLL_W(COLL_W), .PROC_W(PROC_W),
        .INTID_W(INTID_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
        .cmd_evt(cmd_evt), .cmd_ready(cmd_ready),
        .lk_req(lk_req), .lk_kind(lk_kind), .lk_dev(lk_dev), .lk_idx(lk_idx),
        .lk_ack(lk_ack), .lk_fault(lk_fault),
        .rsp_valid(rsp_valid), .rsp_coll(rsp_coll), .rsp_proc(rsp_proc),
        .rsp_intid(rsp_intid),
        .dev_ok(dev_ok), .evt_ok(evt_ok), .coll_ok(coll_ok), .proc_ok(proc_ok),
        .held_evt(held_evt),
        .pend_valid(pend_valid), .pend_set(pend_set), .pend_proc(pend_proc),
        .pend_intid(pend_intid), .done(done), .done_stall(done_stall)
    );

    p_dev_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (32'(cmd_dev) >= DEV_ENTRIES) |=> done && !done_stall)
        else $error("out-of-range device not rejected");

    p_proc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> 32'(pend_proc) < NUM_PROC)
        else $error("pending update to nonexistent processor");

endmodule

// File: tb/etd_translator_bench.sv
`timescale 1ns/1ps
module etd_translator_bench;

    localparam int unsigned DEV_W = 3, EVT_W = 3, COLL_W = 3, PROC_W = 2;
    localparam int unsigned INTID_W = 16, ENTRY_W = 32;
    localparam int unsigned DEV_N = 6, COLL_N = 5, PROC_N = 3;
    localparam int unsigned IDX_W = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [1:0]         cmd_op = '0;
    logic [DEV_W-1:0]   cmd_dev = '0;
    logic [EVT_W-1:0]   cmd_evt = '0;
    logic               lk_req;
    logic [1:0]         lk_kind;
    logic [DEV_W-1:0]   lk_dev;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_ack = 1'b0;
    logic               lk_fault = 1'b0;
    logic [ENTRY_W-1:0] lk_rdata = '0;
    logic               pend_valid, pend_set, done, done_stall;
    logic [PROC_W-1:0]  pend_proc;
    logic [INTID_W-1:0] pend_intid;

    etd_translator #(
        .DEV_W(DEV_W), .EVT_W(EVT_W), .COLL_W(COLL_W), .PROC_W(PROC_W),
        .INTID_W(INTID_W), .ENTRY_W(ENTRY_W), .DEV_ENTRIES(DEV_N),
        .COLL_ENTRIES(COLL_N), .NUM_PROC(PROC_N)
    ) u_etd_translator (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_evt(cmd_evt),
        .lk_req(lk_req), .lk_kind(lk_kind), .lk_dev(lk_dev), .lk_idx(lk_idx),
        .lk_ack(lk_ack), .lk_fault(lk_fault), .lk_rdata(lk_rdata),
        .pend_valid(pend_valid), .pend_set(pend_set), .pend_proc(pend_proc),
        .pend_intid(pend_intid), .done(done), .done_stall(done_stall)
    );

    always #2 clk = ~clk;

    int n_total = 0, n_fail = 0;
    bit finished = 0;

    // Stimulus context shared with the responder and the monitor.
    int g_d, g_e, g_fault, g_lat;
    int n_req, key_err, n_pend, wait_cnt;
    int log_kind [8];
    int seen_proc, seen_intid, seen_set;

    // Arithmetic table contents.
    function automatic bit dev_v(int d);   return (d % 4) != 3; endfunction
    function automatic int dev_sz(int d);  return d % 3; endfunction
    function automatic bit xlt_v(int d, int e); return ((d + e) % 5) != 0; endfunction
    function automatic int xlt_c(int d, int e); return (d * 3 + e) % 7; endfunction
    function automatic int xlt_i(int d, int e); return 100 + d * 16 + e; endfunction
    function automatic bit col_v(int c);   return c != 2; endfunction
    function automatic int col_p(int c);   return c % 4; endfunction

    function automatic logic [ENTRY_W-1:0] entry(int kind, int d, int e, int c);
        logic [ENTRY_W-1:0] w = '0;
        if (kind == 0) begin
            w[0] = dev_v(d); w[5:1] = 5'(dev_sz(d));
        end else if (kind == 1) begin
            w[0] = xlt_v(d, e); w[3:1] = 3'(xlt_c(d, e)); w[24:9] = 16'(xlt_i(d, e));
        end else if (kind == 2) begin
            w[0] = col_v(c); w[2:1] = 2'(col_p(c));
        end
        return w;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Lookup responder: latency g_lat cycles, fault at kind g_fault-1.
    initial begin
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (lk_req) begin
                if (wait_cnt < g_lat) begin
                    wait_cnt++;
                    lk_ack = 1'b0;
                end else begin
                    wait_cnt = 0;
                    lk_ack = 1'b1;
                    lk_fault = (g_fault == int'(lk_kind) + 1);
                    lk_rdata = entry(int'(lk_kind), g_d, g_e, int'(lk_idx));
                    if (n_req < 8) log_kind[n_req] = int'(lk_kind);
                    n_req++;
                    if (int'(lk_dev) != g_d) key_err++;
                    if (lk_kind == 2'd0 && lk_idx != '0) key_err++;
                    if ((lk_kind == 2'd1 || lk_kind == 2'd3) && int'(lk_idx) != g_e) key_err++;
                    if (lk_kind == 2'd2 && int'(lk_idx) != xlt_c(g_d, g_e)) key_err++;
                end
            end else begin
                lk_ack = 1'b0;
                lk_fault = 1'b0;
            end
        end
    end

    // Pending-update monitor.
    initial forever begin
        @(negedge clk);
        if (pend_valid) begin
            n_pend++;
            seen_proc = int'(pend_proc);
            seen_intid = int'(pend_intid);
            seen_set = int'(pend_set);
        end
    end

    task automatic run_cmd(int op, int d, int e, int f);
        string reason;
        int exp_n = 0, exp_stall = 0, exp_pend = 0, c, t;
        bit order_ok = 1;
        g_d = d; g_e = e; g_fault = f; g_lat = (d + e + f) % 3;
        n_req = 0; key_err = 0; n_pend = 0;
        c = xlt_c(d, e);
        reason = "R1";
        if (d < int'(DEV_N)) begin
            exp_n = 1;
            if (f == 1) begin exp_stall = 1; reason = "R9"; end
            else if (!dev_v(d)) reason = "R2";
            else if (e >= (1 << (dev_sz(d) + 1))) reason = "R3";
            else begin
                exp_n = 2;
                if (f == 2) begin exp_stall = 1; reason = "R9"; end
                else if (!xlt_v(d, e)) reason = "R4";
                else if (c >= int'(COLL_N)) reason = "R5";
                else begin
                    exp_n = 3;
                    if (f == 3) begin exp_stall = 1; reason = "R9"; end
                    else if (!col_v(c) || col_p(c) >= int'(PROC_N)) reason = "R6";
                    else begin
                        exp_pend = 1; reason = "R7";
                        if (op == 2) begin
                            exp_n = 4; reason = "R8"; exp_stall = (f == 4);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_dev = 3'(d); cmd_evt = 3'(e);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R11", "ready while busy", int'(cmd_ready), 0);
        t = 0;
        while (!done && t < 100) begin @(negedge clk); t++; end
        check(done && int'(done_stall) == exp_stall, reason, "verdict stall",
              int'(done_stall), exp_stall);
        for (int i = 0; i < 4 && i < n_req; i++) if (log_kind[i] != i) order_ok = 0;
        check(n_req == exp_n && order_ok && key_err == 0, reason,
              "R10 lookup count/order/keys", n_req * 100 + key_err, exp_n * 100);
        check(n_pend == exp_pend, reason, "R7 pending pulses", n_pend, exp_pend);
        if (exp_pend == 1 && n_pend == 1) begin
            check(seen_proc == col_p(c) && seen_intid == xlt_i(d, e) &&
                  seen_set == (op == 0 ? 1 : 0), "R7", "pend fields",
                  seen_proc * 100000 + seen_intid * 10 + seen_set,
                  col_p(c) * 100000 + xlt_i(d, e) * 10 + (op == 0 ? 1 : 0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !done && !lk_req && !pend_valid, "R11", "reset state",
              {28'd0, cmd_ready, done, lk_req, pend_valid}, 8);
        for (int f = 0; f <= 4; f++)
            for (int op = 0; op < 4; op++)
                for (int d = 0; d < 8; d++)
                    for (int e = 0; e < 8; e++)
                        run_cmd(op, d, e, f);
        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule